// File: doc/BRIEF.md
# Single-Clock FIFO with Programmable Fill Flags

This block is a single-clock first-in first-out buffer for 9-bit words, with a depth parameter from 256 to 4096 entries. It reports four active-low status flags (empty, almost-empty, almost-full, full). All four are registered, and each one changes on the same clock edge as the write or read that moves the fill level. The two almost-flag thresholds arrive as inputs from a companion offset register block. That block resets them to 7.

One input, `wr_en2_ld`, serves two purposes. Its level while reset is held low fixes the write-side mode until the next reset:
- **High:** the pin acts as a second, active-high write enable, which is used when buffers are chained in depth.
- **Low:** the pin becomes a load select. A write cycle taken with the pin low is handed to the offset block as a strobe and does not enter the data array.

The read side has two active-low read enables and a registered output word. An active-low output enable drives a separate drive indication, and the data output reads zero while it is not driven.

Top module: `prog_flag_fifo`

## Requirements
- R1: While `rst_n` is low, the fill level returns to zero: `empty_n` and `aempty_n` read 0, and `full_n` and `afull_n` read 1, after the next clock edge.
- R2: While `rst_n` is low, the output word register is cleared to all zeros.
- R3: The level of `wr_en2_ld` at the clock edges during reset selects the mode. 1 selects dual-write-enable mode and 0 selects offset-load mode. The mode holds until the next reset.
- R4: A word enters the array on a rising edge only when `wr_en1_n`=0 and `wr_en2_ld`=1. With `wr_en2_ld`=0 in dual-write-enable mode, nothing happens.
- R5: A word is moved to the output register only when `rd_en1_n`=0 and `rd_en2_n`=0. Otherwise the output register keeps its value.
- R6: Writes are ignored while `full_n`=0, and reads are ignored while `empty_n`=0. Stored data and the flags are not disturbed.
- R7: `aempty_n` is 0 when the level is at most `ae_ofs` words, and 1 from `ae_ofs`+1 words upward.
- R8: `afull_n` is 0 when the level is at least DEPTH-`af_ofs` words, and 1 below that.
- R9: `full_n` goes to 0 on the edge of the DEPTH-th write when no reads occur after reset.
- R10: In offset-load mode, a cycle with `wr_en1_n`=0 and `wr_en2_ld`=0 asserts `ofs_wr` in that cycle and leaves the array and the level unchanged.
- R11: A read and a write on the same edge are both performed when the flags permit, and the level stays the same. Data keeps first-in first-out order.
- R12: `rd_drive` equals the inverse of `oe_n`. While it is 0, `rd_data` reads zero; while it is 1, `rd_data` shows the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_data | input | DATA_W | Word to store, or offset value in load cycles |
| wr_en1_n | input | 1 | Primary write enable, active low |
| wr_en2_ld | input | 1 | Second write enable (high active) or load select (low active), chosen at reset |
| rd_en1_n | input | 1 | Read enable one, active low |
| rd_en2_n | input | 1 | Read enable two, active low |
| oe_n | input | 1 | Output enable, active low |
| ae_ofs | input | log2(DEPTH) | Almost-empty threshold n |
| af_ofs | input | log2(DEPTH) | Almost-full threshold m |
| rd_data | output | DATA_W | Output word, zero when not driven |
| rd_drive | output | 1 | High when the output is driven |
| empty_n | output | 1 | Low when empty |
| aempty_n | output | 1 | Low when level is n or fewer |
| full_n | output | 1 | Low when full |
| afull_n | output | 1 | Low when level is DEPTH-m or more |
| ofs_wr | output | 1 | Strobe to the offset block in load cycles |

## Verification
The bench applies four kinds of stimulus:
- **Fill and drain:** a steady fill to full and a full drain walk the level across every flag threshold, so an off-by-one at n, DEPTH-m or DEPTH shows up as a flag one cycle early or late.
- **Single enable asserted:** reads with only one enable low, and writes with the second enable low, separate a correct two-enable condition from one that tests a single pin.
- **Beyond the ends:** extra writes while full and extra reads while empty show whether blocked operations corrupt the pointers, because every word read afterwards is compared against a scoreboard.
- **Mixed and mode cycles:** simultaneous read/write cycles, changed thresholds, output-enable toggling and a second reset into load mode separate level tracking, threshold use, output gating and mode capture.

// File: rtl/pff_pkg.sv
package pff_pkg;
   typedef enum logic {
      MODE_DUAL_WEN = 1'b0,
      MODE_OFS_LOAD = 1'b1
   } pff_mode_e;

   function automatic pff_mode_e mode_from_pin(input logic pin);
      return pin ? MODE_DUAL_WEN : MODE_OFS_LOAD;
   endfunction
endpackage

// File: rtl/pff_ctrl.sv
module pff_ctrl
   import pff_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en1_n,
   input  logic wr_en2_ld,
   input  logic rd_en1_n,
   input  logic rd_en2_n,
   input  logic empty_n,
   input  logic full_n,
   output logic wr_fire,
   output logic rd_fire,
   output logic ofs_wr
);
   pff_mode_e mode_q;

   // mode is captured on every edge that sees reset low
   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= mode_from_pin(wr_en2_ld);
   end

   // in both modes a data write needs enable one low and the dual pin high
   assign wr_fire = rst_n & ~wr_en1_n & wr_en2_ld & full_n;
   assign rd_fire = rst_n & ~rd_en1_n & ~rd_en2_n & empty_n;
   assign ofs_wr  = rst_n & (mode_q == MODE_OFS_LOAD) & ~wr_en1_n & ~wr_en2_ld;
endmodule

// File: rtl/pff_store.sv
module pff_store #(
   parameter int DATA_W = 9,
   parameter int DEPTH  = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_fire,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_fire,
   output logic [DATA_W-1:0] out_q
);
   localparam int AW   = $clog2(DEPTH);
   localparam bit POW2 = ((1 << AW) == DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wp, rp, wp_inc, rp_inc;

   generate
      if (POW2) begin : g_wrap_free
         assign wp_inc = wp + 1'b1;
         assign rp_inc = rp + 1'b1;
      end else begin : g_wrap_cmp
         localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
         assign wp_inc = (wp == LAST) ? '0 : wp + 1'b1;
         assign rp_inc = (rp == LAST) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_fire) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         out_q <= '0;
      end else begin
         if (wr_fire) wp <= wp_inc;
         if (rd_fire) begin
            rp    <= rp_inc;
            out_q <= mem[rp];
         end
      end
   end
endmodule

// File: rtl/pff_level.sv
module pff_level #(
   parameter int DEPTH = 256
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_fire,
   input  logic                     rd_fire,
   input  logic [$clog2(DEPTH)-1:0] ae_ofs,
   input  logic [$clog2(DEPTH)-1:0] af_ofs,
   output logic                     empty_n,
   output logic                     aempty_n,
   output logic                     full_n,
   output logic                     afull_n
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam int SW = CW + 1;
   localparam logic [SW-1:0] DEPTH_S = SW'(DEPTH);

   logic [CW-1:0] lvl_q, lvl_d;
   logic [SW-1:0] lvl_s, af_sum;

   always_comb begin
      lvl_d = lvl_q;
      if (wr_fire && !rd_fire) lvl_d = lvl_q + 1'b1;
      if (rd_fire && !wr_fire) lvl_d = lvl_q - 1'b1;
   end

   assign lvl_s  = SW'(lvl_d);
   assign af_sum = lvl_s + SW'(af_ofs);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q    <= '0;
         empty_n  <= 1'b0;
         aempty_n <= 1'b0;
         full_n   <= 1'b1;
         afull_n  <= 1'b1;
      end else begin
         lvl_q    <= lvl_d;
         empty_n  <= (lvl_s != '0);
         aempty_n <= (lvl_s > SW'(ae_ofs));
         full_n   <= (lvl_s != DEPTH_S);
         afull_n  <= (af_sum < DEPTH_S);
      end
   end
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo #(
   parameter int DATA_W    = 9,
   parameter int DEPTH     = 256,
   parameter int MIN_DEPTH = 256,
   parameter int MAX_DEPTH = 4096,
   localparam int OW       = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_en1_n,
   input  logic              wr_en2_ld,
   input  logic              rd_en1_n,
   input  logic              rd_en2_n,
   input  logic              oe_n,
   input  logic [OW-1:0]     ae_ofs,
   input  logic [OW-1:0]     af_ofs,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_drive,
   output logic              empty_n,
   output logic              aempty_n,
   output logic              full_n,
   output logic              afull_n,
   output logic              ofs_wr
);
   generate
      if (DEPTH < MIN_DEPTH || DEPTH > MAX_DEPTH) begin : g_bad_depth
         $error("prog_flag_fifo: DEPTH out of supported range");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("prog_flag_fifo: DATA_W must be positive");
      end
   endgenerate

   logic              wr_fire, rd_fire;
   logic [DATA_W-1:0] out_q;

   pff_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en1_n (wr_en1_n),
      .wr_en2_ld(wr_en2_ld),
      .rd_en1_n (rd_en1_n),
      .rd_en2_n (rd_en2_n),
      .empty_n  (empty_n),
      .full_n   (full_n),
      .wr_fire  (wr_fire),
      .rd_fire  (rd_fire),
      .ofs_wr   (ofs_wr)
   );

   pff_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_fire(wr_fire),
      .wr_data(wr_data),
      .rd_fire(rd_fire),
      .out_q  (out_q)
   );

   pff_level #(.DEPTH(DEPTH)) u_level (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_fire (wr_fire),
      .rd_fire (rd_fire),
      .ae_ofs  (ae_ofs),
      .af_ofs  (af_ofs),
      .empty_n (empty_n),
      .aempty_n(aempty_n),
      .full_n  (full_n),
      .afull_n (afull_n)
   );

   assign rd_drive = ~oe_n;
   assign rd_data  = rd_drive ? out_q : '0;
endmodule

// File: rtl/pff_chk.sv
module pff_chk #(
   parameter int DATA_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en1_n,
   input logic              rd_en2_n,
   input logic              empty_n,
   input logic              aempty_n,
   input logic              full_n,
   input logic              afull_n,
   input logic              ofs_wr,
   input logic [DATA_W-1:0] out_q
);
   logic rst_seen = 1'b0;
   always_ff @(posedge clk) begin
      if (!rst_n) rst_seen <= 1'b1;
   end

   // R1 R2: one edge under reset leaves the flags and the output word at rest
   a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_seen)
      $past(!rst_n) |-> (!empty_n && !aempty_n && full_n && afull_n && out_q == '0));

   // R5: without both read enables the output word holds
   a_r5_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en1_n || rd_en2_n) |=> $stable(out_q));

   // R6: a full buffer with no read stays full
   a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_n && (rd_en1_n || rd_en2_n)) |=> !full_n);

   // R6: an empty buffer never changes the output word
   a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      !empty_n |=> $stable(out_q));

   // R7: empty implies almost empty
   a_r7_empty_in_ae: assert property (@(posedge clk) disable iff (!rst_n)
      !empty_n |-> !aempty_n);

   // R8: full implies almost full
   a_r8_full_in_af: assert property (@(posedge clk) disable iff (!rst_n)
      !full_n |-> !afull_n);

   // R10: an offset load cycle without a read leaves the level flags alone
   a_r10_load_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (ofs_wr && (rd_en1_n || rd_en2_n)) |=> ($stable(empty_n) && $stable(full_n)));
endmodule

bind prog_flag_fifo pff_chk #(.DATA_W(DATA_W)) u_pff_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rd_en1_n(rd_en1_n),
   .rd_en2_n(rd_en2_n),
   .empty_n (empty_n),
   .aempty_n(aempty_n),
   .full_n  (full_n),
   .afull_n (afull_n),
   .ofs_wr  (ofs_wr),
   .out_q   (out_q)
);

// File: tb/prog_flag_fifo_tb.sv
`timescale 1ns/1ps
module prog_flag_fifo_tb_top;
   localparam int DW    = 9;
   localparam int DEPTH = 256;
   localparam int OW    = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_en1_n = 1'b1, wr_en2_ld = 1'b1;
   logic          rd_en1_n = 1'b1, rd_en2_n = 1'b1, oe_n = 1'b0;
   logic [OW-1:0] ae_ofs = OW'(7), af_ofs = OW'(7);
   logic [DW-1:0] rd_data;
   logic          rd_drive, empty_n, aempty_n, full_n, afull_n, ofs_wr;

   always #10 clk = ~clk;

   prog_flag_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_en1_n(wr_en1_n),
      .wr_en2_ld(wr_en2_ld), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
      .oe_n(oe_n), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .rd_data(rd_data),
      .rd_drive(rd_drive), .empty_n(empty_n), .aempty_n(aempty_n),
      .full_n(full_n), .afull_n(afull_n), .ofs_wr(ofs_wr)
   );

   // model state
   logic [DW-1:0] sb_q[$];
   int            lvl = 0;
   logic          load_mode = 1'b0;
   logic [DW-1:0] m_out = '0;
   logic          e_ofs = 1'b0;
   logic          chk_en = 1'b0;
   string         tag = "R1";
   int            n_vec = 0, n_bad = 0;
   bit            done = 1'b0;

   task automatic chk(string f, int got, int exp);
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s got %0h expected %0h", tag, f, got, exp);
      end
   endtask

   // driver: applies one cycle of stimulus and predicts the state after the edge
   task automatic step(bit rst, bit w1n, bit w2, bit r1n, bit r2n, logic [DW-1:0] d);
      bit wf, rf;
      @(negedge clk);
      rst_n = rst; wr_en1_n = w1n; wr_en2_ld = w2;
      rd_en1_n = r1n; rd_en2_n = r2n; wr_data = d;
      if (!rst) begin
         load_mode = ~w2; lvl = 0; sb_q.delete(); m_out = '0; e_ofs = 1'b0;
      end else begin
         wf = !w1n && w2 && (lvl != DEPTH);
         rf = !r1n && !r2n && (lvl != 0);
         e_ofs = load_mode && !w1n && !w2;
         if (rf) m_out = sb_q.pop_front();
         if (wf) sb_q.push_back(d);
         lvl = lvl + int'(wf) - int'(rf);
      end
      chk_en = 1'b1;
   endtask

   task automatic wr(logic [DW-1:0] d); step(1, 0, 1, 1, 1, d); endtask
   task automatic rd();                 step(1, 1, 1, 0, 0, '0); endtask
   task automatic idle();               step(1, 1, 1, 1, 1, '0); endtask

   // monitor: compares the ports against the scoreboard after every edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (chk_en) begin
            n_vec++;
            chk("empty_n",  int'(empty_n),  int'(lvl != 0));
            chk("full_n",   int'(full_n),   int'(lvl != DEPTH));
            chk("aempty_n", int'(aempty_n), int'(lvl > int'(ae_ofs)));
            chk("afull_n",  int'(afull_n),  int'(lvl + int'(af_ofs) < DEPTH));
            chk("rd_data",  int'(rd_data),  oe_n ? 0 : int'(m_out));
            chk("rd_drive", int'(rd_drive), int'(!oe_n));
            chk("ofs_wr",   int'(ofs_wr),   int'(e_ofs));
         end
      end
   end

   initial begin
      // R1 R2 R3: reset with the dual pin high selects dual-write-enable mode
      tag = "R1/R2";
      for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, 9'h1AA);
      tag = "R4";
      step(1, 0, 0, 1, 1, 9'h055);   // second enable low: no write, no strobe (R3)
      step(1, 1, 1, 1, 1, 9'h066);   // enable one high: no write
      for (int i = 1; i <= 5; i++) wr(DW'(i * 7));
      tag = "R5";
      step(1, 1, 1, 0, 1, '0);       // only one read enable low
      step(1, 1, 1, 1, 0, '0);
      rd(); rd();
      tag = "R7";
      for (int i = 0; i < 6; i++) wr(DW'(9'h100 + i)); // crosses level 7 -> 8
      for (int i = 0; i < 9; i++) rd();              // back down through 7
      tag = "R6";
      rd(); rd();                                    // reads while empty
      tag = "R9";
      for (int i = 0; i < DEPTH; i++) wr(DW'(i * 3 + 1)); // afull at 249 (R8), full at 256
      tag = "R6";
      for (int i = 0; i < 4; i++) wr(9'h1FF);         // writes while full
      tag = "R8";
      for (int i = 0; i < DEPTH; i++) rd();
      tag = "R6";
      rd();
      tag = "R11";
      step(1, 0, 1, 0, 0, 9'h011);    // both at empty: only the write happens
      wr(9'h012); wr(9'h013);
      for (int i = 0; i < 6; i++) step(1, 0, 1, 0, 0, DW'(9'h020 + i));
      for (int i = 0; i < 9; i++) rd();
      tag = "R7/R8 programmed";
      ae_ofs = OW'(3); af_ofs = OW'(20);
      for (int i = 0; i < 240; i++) wr(DW'(i ^ 9'h0A5));
      for (int i = 0; i < 240; i++) rd();
      ae_ofs = OW'(7); af_ofs = OW'(7);
      tag = "R12";
      wr(9'h1C3); rd();
      oe_n = 1'b0; idle();
      oe_n = 1'b1; idle(); idle();
      oe_n = 1'b0; idle();
      tag = "R3";
      for (int i = 0; i < 2; i++) step(0, 1, 0, 1, 1, '0);  // reset with pin low
      tag = "R10";
      step(1, 0, 0, 1, 1, 9'h007);  // load cycle: strobe only
      step(1, 0, 0, 1, 1, 9'h00C);
      wr(9'h0B1); wr(9'h0B2);
      step(1, 0, 0, 1, 1, 9'h004);
      rd(); rd(); rd();
      idle();
      @(posedge clk); #3;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog run did not complete");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule